// File: doc/BRIEF.md
# Acquire/Release Cache Maintenance Sequencer

This block sits in front of a GPU first-level data cache and turns memory-ordering flags on incoming requests into cache-wide maintenance. Each request carries an acquire flag, a release flag and a kernel-boundary flag. Release semantics walk every line index and emit one flush (writeback) request per index. Acquire semantics walk every index and emit one invalidate request per index. A combined acquire-release does an invalidate walk followed by a flush walk.

Outstanding flushes and invalidates are counted as they are emitted and retired by completion pulses. While any writeback is pending, whether counted, queued or being walked, ordinary requests are held off and only kernel-boundary requests get through. A kernel-end request is put on a per-context pending set and starts a flush walk. All pending kernel-ends are reported together once the writebacks have drained. Requests that pass on to the normal path appear one cycle after acceptance on a forward port.

Walk orders wait in a small queue. A walk emits at most one maintenance request per cycle under a downstream ready signal, and two walks never mix their indices.

Top module: `acqrel_seq`

## Requirements
- R1: After reset, req_ready is 1, mnt_valid is 0, kdone_valid is 0 and both wb_pend and inv_pend are 0.
- R2: An accepted non-kernel release (req_rel=1, req_acq=0) produces LINES maintenance requests with mnt_kind=1 (flush) and mnt_idx 0,1,...,LINES-1, one per mnt_valid&&mnt_ready cycle. While mnt_ready is 0, mnt_valid, mnt_idx and mnt_kind hold.
- R3: An accepted acquire (req_acq=1, req_rel=0) produces LINES requests with mnt_kind=0 (invalidate) and indices 0 to LINES-1 in order.
- R4: An accepted non-kernel acquire-release produces a complete invalidate walk and then a complete flush walk.
- R5: wb_pend (inv_pend) rises by one per accepted flush (invalidate) request and falls by one per wb_ack (inv_ack) pulse. A pulse while the count is 0 is ignored. An emission and a completion in the same cycle leave the count unchanged.
- R6: While a writeback is pending (wb_pend nonzero, or a flush walk queued or in progress), req_ready is 0 for requests with req_kern=0 and 1 for requests with req_kern=1. A kernel request accepted in this state is not forwarded, apart from the walk rule of R9.
- R7: Pending invalidates alone never lower req_ready.
- R8: A kernel-end (req_kern=1, req_rel=1) sets bit req_ctx of a pending set and is never forwarded. If no writeback is pending it also starts a flush walk. Once no writeback is pending, kdone_valid pulses for one cycle with kdone_mask equal to the pending set (bit c = context c), and the set clears.
- R9: A kernel-begin (req_kern=1, req_acq=1, req_rel=0) accepted while a writeback is pending starts an invalidate walk only if no invalidate is pending, counted, queued or walking.
- R10: A kernel-begin accepted with no writeback pending is forwarded with fwd_kern=1 and fwd_acq=1, and starts an invalidate walk.
- R11: A walk ordered while another walk is queued or running starts only after the earlier walk has emitted index LINES-1. Indices of different walks never interleave.
- R12: Every accepted request that is not a kernel-end and arrives with no writeback pending appears for one cycle on fwd_valid, with its flags and context, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_acq | input | 1 | Acquire semantics |
| req_rel | input | 1 | Release semantics |
| req_kern | input | 1 | Kernel-boundary request |
| req_ctx | input | $clog2(NCTX) | Context of the request |
| fwd_valid | output | 1 | Request passed on to the normal path |
| fwd_acq | output | 1 | Forwarded acquire flag |
| fwd_rel | output | 1 | Forwarded release flag |
| fwd_kern | output | 1 | Forwarded kernel flag |
| fwd_ctx | output | $clog2(NCTX) | Forwarded context |
| mnt_valid | output | 1 | Maintenance request present |
| mnt_ready | input | 1 | Downstream takes the maintenance request |
| mnt_idx | output | $clog2(LINES) | Line index to maintain |
| mnt_kind | output | 1 | 0 invalidate, 1 flush |
| wb_ack | input | 1 | One flush completed |
| inv_ack | input | 1 | One invalidate completed |
| wb_pend | output | $clog2(LINES*(QDEPTH+1)+1) | Outstanding flushes |
| inv_pend | output | $clog2(LINES*(QDEPTH+1)+1) | Outstanding invalidates |
| kdone_valid | output | 1 | Kernel-end completion pulse |
| kdone_mask | output | NCTX | Contexts whose kernel-end completed |

## Verification
The function pair most likely to coincide is a flush emission and a writeback completion, which hit the same counter in the same cycle. The bench waits until two flushes of a release walk are counted, then holds wb_ack high for three cycles while the walk keeps emitting one index per cycle. It then expects the count left after the walk to be exactly LINES-3, with no lost or doubled update. A second overlap, a kernel-end arriving while earlier kernel-ends wait for drain, is judged by a single completion pulse whose mask holds both contexts.

// File: rtl/acqrel_pkg.sv
package acqrel_pkg;
   typedef enum logic {
      MK_INV   = 1'b0,
      MK_FLUSH = 1'b1
   } mkind_t;
endpackage

// File: rtl/acqrel_walkq.sv
module acqrel_walkq
   import acqrel_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   push_a,
   input  mkind_t kind_a,
   input  logic   push_b,
   input  mkind_t kind_b,
   input  logic   pop,
   output logic   empty,
   output mkind_t head,
   output logic   room2,
   output logic   has_flush,
   output logic   has_inv
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("walk queue depth must be a power of two, at least 2");
   end

   mkind_t           slot [DEPTH];
   logic [DEPTH-1:0] occ;
   logic [PW-1:0]    wp, rp, wp_n1;
   logic [CW-1:0]    fill;
   logic [DEPTH-1:0] is_f, is_i;

   for (genvar e = 0; e < DEPTH; e++) begin : g_scan
      assign is_f[e] = occ[e] && (slot[e] == MK_FLUSH);
      assign is_i[e] = occ[e] && (slot[e] == MK_INV);
   end

   assign has_flush = |is_f;
   assign has_inv   = |is_i;
   assign wp_n1     = wp + PW'(1);
   assign empty     = (fill == '0);
   assign head      = slot[rp];
   assign room2     = (fill <= CW'(DEPTH - 2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ  <= '0;
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
         for (int e = 0; e < DEPTH; e++) slot[e] <= MK_INV;
      end else begin
         if (pop) begin
            occ[rp] <= 1'b0;
            rp      <= rp + PW'(1);
         end
         if (push_a) begin
            slot[wp] <= kind_a;
            occ[wp]  <= 1'b1;
         end
         if (push_b) begin
            slot[wp_n1] <= kind_b;
            occ[wp_n1]  <= 1'b1;
         end
         wp   <= wp + PW'(push_a) + PW'(push_b);
         fill <= fill + CW'(push_a) + CW'(push_b) - CW'(pop);
      end
   end

   // R11: queued walk orders are never lost to a full queue
   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      push_a |-> (fill < CW'(DEPTH)));
   assert_pair_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push_a && push_b) |-> (fill <= CW'(DEPTH - 2)));
endmodule

// File: rtl/acqrel_walker.sv
module acqrel_walker
   import acqrel_pkg::*;
#(
   parameter int LINES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     q_empty,
   input  mkind_t                   q_head,
   output logic                     q_pop,
   input  logic                     mnt_ready,
   output logic                     mnt_valid,
   output logic [$clog2(LINES)-1:0] mnt_idx,
   output mkind_t                   mnt_kind
);
   localparam int            IW   = $clog2(LINES);
   localparam logic [IW-1:0] LAST = IW'(LINES - 1);

   if (LINES < 2) begin : g_bad_lines
      $error("walker needs at least two lines");
   end

   logic          active;
   logic [IW-1:0] idx;
   mkind_t        kind;

   assign q_pop     = !active && !q_empty;
   assign mnt_valid = active;
   assign mnt_idx   = idx;
   assign mnt_kind  = kind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         kind   <= MK_INV;
      end else if (q_pop) begin
         active <= 1'b1;
         idx    <= '0;
         kind   <= q_head;
      end else if (active && mnt_ready) begin
         if (idx == LAST) active <= 1'b0;
         else             idx    <= idx + IW'(1);
      end
   end

   // R2: a stalled request holds its index and kind
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && !mnt_ready) |=> (mnt_valid && $stable(mnt_idx) && $stable(mnt_kind)));
   // R11: inside a walk the next request is the next index of the same kind
   assert_no_interleave_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && mnt_ready && mnt_idx != LAST) |=>
      (mnt_valid && mnt_idx == IW'($past(mnt_idx) + 1'b1) && mnt_kind == $past(mnt_kind)));
endmodule

// File: rtl/acqrel_tally.sv
module acqrel_tally #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (cnt != MAXV) cnt <= cnt + W'(1);
            2'b01:   if (cnt != '0)   cnt <= cnt - W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R5: a completion at zero never wraps the count
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !inc) |=> (cnt == '0));
endmodule

// File: rtl/acqrel_seq.sv
module acqrel_seq
   import acqrel_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int NCTX   = 4,
   parameter int QDEPTH = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic                                   req_acq,
   input  logic                                   req_rel,
   input  logic                                   req_kern,
   input  logic [$clog2(NCTX)-1:0]                req_ctx,
   output logic                                   fwd_valid,
   output logic                                   fwd_acq,
   output logic                                   fwd_rel,
   output logic                                   fwd_kern,
   output logic [$clog2(NCTX)-1:0]                fwd_ctx,
   output logic                                   mnt_valid,
   input  logic                                   mnt_ready,
   output logic [$clog2(LINES)-1:0]               mnt_idx,
   output logic                                   mnt_kind,
   input  logic                                   wb_ack,
   input  logic                                   inv_ack,
   output logic [$clog2(LINES*(QDEPTH+1)+1)-1:0]  wb_pend,
   output logic [$clog2(LINES*(QDEPTH+1)+1)-1:0]  inv_pend,
   output logic                                   kdone_valid,
   output logic [NCTX-1:0]                        kdone_mask
);
   localparam int IW   = $clog2(LINES);
   localparam int CTXW = $clog2(NCTX);
   localparam int CNTW = $clog2(LINES * (QDEPTH + 1) + 1);

   if (NCTX < 2) begin : g_bad_ctx
      $error("at least two contexts are required");
   end

   logic   push_a, push_b, q_pop, q_empty, q_room2, q_hf, q_hi;
   mkind_t kind_a, kind_b, q_head, w_kind;
   logic   w_valid;
   logic [IW-1:0] w_idx;

   acqrel_walkq #(.DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push_a(push_a), .kind_a(kind_a), .push_b(push_b), .kind_b(kind_b),
      .pop(q_pop), .empty(q_empty), .head(q_head), .room2(q_room2),
      .has_flush(q_hf), .has_inv(q_hi)
   );

   acqrel_walker #(.LINES(LINES)) u_w (
      .clk(clk), .rst_n(rst_n),
      .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
      .mnt_ready(mnt_ready), .mnt_valid(w_valid), .mnt_idx(w_idx), .mnt_kind(w_kind)
   );

   assign mnt_valid = w_valid;
   assign mnt_idx   = w_idx;
   assign mnt_kind  = w_kind;

   // counters: index 0 invalidates, index 1 flushes
   logic [1:0]      t_inc, t_dec;
   logic [CNTW-1:0] t_cnt [2];
   assign t_dec = {wb_ack, inv_ack};

   for (genvar k = 0; k < 2; k++) begin : g_tally
      assign t_inc[k] = w_valid && mnt_ready && (w_kind == mkind_t'(k));
      acqrel_tally #(.W(CNTW)) u_t (
         .clk(clk), .rst_n(rst_n), .inc(t_inc[k]), .dec(t_dec[k]), .cnt(t_cnt[k])
      );
   end

   assign inv_pend = t_cnt[0];
   assign wb_pend  = t_cnt[1];

   logic wb_busy, inv_busy, is_kend, is_kbeg, acc, fwd_go, kd_fire;
   logic [NCTX-1:0] ke_pend, ke_new;

   assign wb_busy   = (wb_pend != '0)  || (w_valid && w_kind == MK_FLUSH) || q_hf;
   assign inv_busy  = (inv_pend != '0) || (w_valid && w_kind == MK_INV)   || q_hi;
   assign is_kend   = req_kern && req_rel;
   assign is_kbeg   = req_kern && req_acq && !req_rel;
   assign req_ready = q_room2 && (!wb_busy || req_kern);
   assign acc       = req_valid && req_ready;
   assign kd_fire   = !wb_busy && (ke_pend != '0);

   always_comb begin
      push_a = 1'b0;
      kind_a = MK_INV;
      push_b = 1'b0;
      kind_b = MK_FLUSH;
      fwd_go = 1'b0;
      ke_new = '0;
      if (acc) begin
         if (wb_busy) begin
            if (is_kend)                    ke_new[req_ctx] = 1'b1;
            else if (is_kbeg && !inv_busy)  push_a = 1'b1;
         end else if (is_kend) begin
            ke_new[req_ctx] = 1'b1;
            push_a = 1'b1;
            kind_a = MK_FLUSH;
         end else begin
            fwd_go = 1'b1;
            if (req_acq && req_rel) begin
               push_a = 1'b1;
               push_b = 1'b1;
            end else if (req_rel) begin
               push_a = 1'b1;
               kind_a = MK_FLUSH;
            end else if (req_acq) begin
               push_a = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid   <= 1'b0;
         fwd_acq     <= 1'b0;
         fwd_rel     <= 1'b0;
         fwd_kern    <= 1'b0;
         fwd_ctx     <= '0;
         ke_pend     <= '0;
         kdone_valid <= 1'b0;
         kdone_mask  <= '0;
      end else begin
         fwd_valid <= fwd_go;
         if (fwd_go) begin
            fwd_acq  <= req_acq;
            fwd_rel  <= req_rel;
            fwd_kern <= req_kern;
            fwd_ctx  <= req_ctx;
         end
         ke_pend     <= (kd_fire ? '0 : ke_pend) | ke_new;
         kdone_valid <= kd_fire;
         kdone_mask  <= kd_fire ? ke_pend : '0;
      end
   end

   // R8: kernel-end completion only after the writeback count has drained
   assert_kdone_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kdone_valid |-> ($past(wb_pend) == '0 && kdone_mask != '0));
   // R6: an ordinary request is forwarded only with no writeback counted
   assert_fwd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_kern) |-> ($past(wb_pend) == '0));
   // R8: kernel-end requests never reach the forward port
   assert_kend_absorbed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !(fwd_kern && fwd_rel));
endmodule

// File: tb/sim_acqrel_seq.sv
module sim_acqrel_seq;
   localparam int CLK    = 10;
   localparam int LINES  = 8;
   localparam int NCTX   = 4;
   localparam int QDEPTH = 4;
   localparam int CNTW   = $clog2(LINES * (QDEPTH + 1) + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_acq = 1'b0, req_rel = 1'b0, req_kern = 1'b0;
   logic [1:0] req_ctx = '0;
   logic req_ready, fwd_valid, fwd_acq, fwd_rel, fwd_kern;
   logic [1:0] fwd_ctx;
   logic mnt_valid, mnt_ready, mnt_kind;
   logic [2:0] mnt_idx;
   logic wb_ack = 1'b0, inv_ack = 1'b0;
   logic [CNTW-1:0] wb_pend, inv_pend;
   logic kdone_valid;
   logic [NCTX-1:0] kdone_mask;

   acqrel_seq #(.LINES(LINES), .NCTX(NCTX), .QDEPTH(QDEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_acq(req_acq), .req_rel(req_rel), .req_kern(req_kern), .req_ctx(req_ctx),
      .fwd_valid(fwd_valid), .fwd_acq(fwd_acq), .fwd_rel(fwd_rel), .fwd_kern(fwd_kern),
      .fwd_ctx(fwd_ctx), .mnt_valid(mnt_valid), .mnt_ready(mnt_ready), .mnt_idx(mnt_idx),
      .mnt_kind(mnt_kind), .wb_ack(wb_ack), .inv_ack(inv_ack), .wb_pend(wb_pend),
      .inv_pend(inv_pend), .kdone_valid(kdone_valid), .kdone_mask(kdone_mask)
   );

   always #(CLK / 2) clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // downstream ready, optionally stalling
   logic [7:0] lf = 8'hA5;
   bit stall_en = 0;
   always @(negedge clk) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mnt_ready = stall_en ? lf[0] : 1'b1;
   end

   // monitor, sampling just before each rising edge
   int ln = 0, fwd_n = 0, kd_n = 0, hold_bad = 0;
   int lk [64];
   int li [64];
   logic [NCTX-1:0] kd_mask = '0;
   bit hold_p = 0;
   int h_idx = 0, h_kind = 0;
   logic l_acq = 0, l_kern = 0, l_rel = 0;
   int l_ctx = 0;
   always begin
      @(negedge clk);
      #(CLK / 2 - 1);
      if (rst_n) begin
         if (hold_p && !(mnt_valid && int'(mnt_idx) == h_idx && int'(mnt_kind) == h_kind))
            hold_bad++;
         hold_p = mnt_valid && !mnt_ready;
         h_idx  = int'(mnt_idx);
         h_kind = int'(mnt_kind);
         if (mnt_valid && mnt_ready && ln < 64) begin
            lk[ln] = int'(mnt_kind);
            li[ln] = int'(mnt_idx);
            ln++;
         end
         if (fwd_valid) begin
            fwd_n++;
            l_acq = fwd_acq; l_rel = fwd_rel; l_kern = fwd_kern; l_ctx = int'(fwd_ctx);
         end
         if (kdone_valid) begin
            kd_n++;
            kd_mask = kdone_mask;
         end
      end
   end

   task automatic send(input logic a, input logic r, input logic k, input logic [1:0] c);
      @(negedge clk);
      req_valid = 1'b1; req_acq = a; req_rel = r; req_kern = k; req_ctx = c;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_acq = 0; req_rel = 0; req_kern = 0;
   endtask

   task automatic probe(input logic a, input logic r, input logic k, output logic rdy);
      @(negedge clk);
      req_valid = 1'b1; req_acq = a; req_rel = r; req_kern = k;
      #1;
      rdy = req_ready;
      req_valid = 1'b0; req_acq = 0; req_rel = 0; req_kern = 0;
   endtask

   task automatic wait_log(input int n);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         #1;
         if (ln >= n) break;
      end
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic ack(input bit wb, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wb) wb_ack = 1'b1; else inv_ack = 1'b1;
         @(negedge clk);
         wb_ack = 1'b0; inv_ack = 1'b0;
      end
      #1;
   endtask

   function automatic int walk_bad(input int base, input int kind);
      int bad = 0;
      for (int i = 0; i < LINES; i++)
         if (lk[base + i] != kind || li[base + i] != i) bad++;
      return bad;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      #1;
      check("R1 req_ready", int'(req_ready), 1);
      check("R1 mnt_valid", int'(mnt_valid), 0);
      check("R1 wb_pend", int'(wb_pend), 0);
      check("R1 inv_pend", int'(inv_pend), 0);
      check("R1 kdone_valid", int'(kdone_valid), 0);
   endtask

   task automatic t_release();
      logic rdy;
      int f0, f1;
      ln = 0; f0 = fwd_n;
      send(0, 1, 0, 0);
      wait_log(LINES);
      check("R2 flush walk count", ln, LINES);
      check("R2 flush walk order", walk_bad(0, 1), 0);
      check("R12 release forwarded", fwd_n, f0 + 1);
      check("R12 forwarded rel flag", int'(l_rel), 1);
      check("R5 wb_pend after walk", int'(wb_pend), LINES);
      probe(0, 0, 0, rdy);
      check("R6 plain held", int'(rdy), 0);
      probe(1, 0, 0, rdy);
      check("R6 acquire held", int'(rdy), 0);
      f1 = fwd_n;
      send(0, 0, 1, 1);
      repeat (4) @(negedge clk);
      #1;
      check("R6 kernel barrier not forwarded", fwd_n, f1);
      check("R6 kernel barrier starts no walk", ln, LINES);
      ack(1, LINES);
      check("R5 wb_pend drained", int'(wb_pend), 0);
      probe(0, 0, 0, rdy);
      check("R6 plain accepted after drain", int'(rdy), 1);
      ack(1, 1);
      check("R5 completion at zero ignored", int'(wb_pend), 0);
   endtask

   task automatic t_acquire_stall();
      logic rdy;
      int f0;
      ln = 0;
      stall_en = 1;
      send(1, 0, 0, 0);
      wait_log(LINES);
      check("R3 invalidate walk count", ln, LINES);
      check("R3 invalidate walk order", walk_bad(0, 0), 0);
      check("R2 stalled request held", hold_bad, 0);
      check("R5 inv_pend after walk", int'(inv_pend), LINES);
      stall_en = 0;
      probe(0, 0, 0, rdy);
      check("R7 invalidates do not block", int'(rdy), 1);
      f0 = fwd_n;
      send(0, 0, 0, 2);
      repeat (2) @(negedge clk);
      #1;
      check("R7 plain forwarded with inv pending", fwd_n, f0 + 1);
      check("R12 forwarded context", l_ctx, 2);
      ack(0, LINES);
      check("R5 inv_pend drained", int'(inv_pend), 0);
   endtask

   task automatic t_acqrel();
      ln = 0;
      send(1, 1, 0, 1);
      wait_log(2 * LINES);
      check("R4 two walks", ln, 2 * LINES);
      check("R4 invalidate walk first", walk_bad(0, 0), 0);
      check("R11 flush walk after, not interleaved", walk_bad(LINES, 1), 0);
      check("R4 wb_pend", int'(wb_pend), LINES);
      check("R4 inv_pend", int'(inv_pend), LINES);
      ack(1, LINES);
      ack(0, LINES);
   endtask

   task automatic t_kend();
      int f0, k0;
      ln = 0; f0 = fwd_n; k0 = kd_n;
      send(0, 1, 1, 2);
      send(0, 1, 1, 1);
      send(1, 0, 1, 3);
      send(1, 0, 1, 0);
      wait_log(2 * LINES);
      repeat (20) @(negedge clk);
      #1;
      check("R9 one invalidate walk only", ln, 2 * LINES);
      check("R8 kernel-end flush walk", walk_bad(0, 1), 0);
      check("R9 invalidate walk after flush", walk_bad(LINES, 0), 0);
      check("R8 kernel requests not forwarded", fwd_n, f0);
      check("R8 no completion before drain", kd_n, k0);
      ack(1, LINES);
      repeat (3) @(negedge clk);
      #1;
      check("R8 one completion pulse", kd_n, k0 + 1);
      check("R8 completion mask", int'(kd_mask), 6);
      ack(0, LINES);
   endtask

   task automatic t_kbegin_idle();
      int f0;
      ln = 0; f0 = fwd_n;
      send(1, 0, 1, 3);
      wait_log(LINES);
      check("R10 invalidate walk", walk_bad(0, 0), 0);
      check("R10 forwarded", fwd_n, f0 + 1);
      check("R10 forwarded kern flag", int'(l_kern), 1);
      check("R10 forwarded acq flag", int'(l_acq), 1);
      ack(0, LINES);
   endtask

   task automatic t_overlap();
      ln = 0;
      send(0, 1, 0, 0);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         #1;
         if (wb_pend == CNTW'(2)) break;
      end
      wb_ack = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      wb_ack = 1'b0;
      wait_log(LINES);
      check("R5 same-cycle emit and complete", int'(wb_pend), LINES - 3);
      ack(1, LINES - 3);
      check("R5 drained after overlap", int'(wb_pend), 0);
   endtask

   initial begin
      mnt_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_release();
      t_acquire_stall();
      t_acqrel();
      t_kend();
      t_kbegin_idle();
      t_overlap();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK * 150000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule